// File: doc/BRIEF.md
# Quadrature Encoder Channel Status Capture

This block serves one auxiliary encoder channel. It brings the A and B quadrature inputs into the clock domain and decodes every edge into an up or down step of a position counter. A sample in which both A and B change at once breaks the quadrature rule, and the block keeps a sticky flag for it. A timer that advances on a serial-clock enable measures how many enables pass between the two most recent valid counts.

The block captures the three Hall sensor lines at every valid count. It also registers a flag, supplied from outside, that reports a bad multiplexed-input sample. A compare output goes high while the position equals a programmable value. The results are read out as two words: a 16-bit status word and an inter-count period word.

Top module: `enc_status_capture`

## Requirements
- R1: A and B each pass through two synchronizing flops and a previous-sample flop. A level change on A or B that is driven between rising edges shows in `position` after the third rising edge that follows it, and not before.
- R2: The counter counts every edge (four counts per quadrature cycle). The {A,B} sequence 00→10→11→01→00 adds one per step, the reverse sequence subtracts one per step, and the count wraps modulo 2^CNT_W.
- R3: A sample in which A and B both differ from the previous sample is illegal. It leaves `position` unchanged and sets status bit 8 one edge later. The bit stays set until it is cleared.
- R4: `cnt_clr` high at a rising edge sets `position` to 0 and clears status bit 8. It takes priority over a step or an illegal transition in the same cycle.
- R5: The timer counts cycles with `sclk_en` high. At each valid count, `period_word` takes the timer value plus one if `sclk_en` is high in that cycle, and the timer restarts from 0.
- R6: The timer and `period_word` saturate at 2^TMR_W−1 instead of wrapping.
- R7: Status bits 2:0 hold `hall_uvw` as sampled at the most recent valid count, with U on bit 2. Between counts they do not change.
- R8: Status bit 3 is `demux_err` registered by one edge.
- R9: Status bits 7:4 and 15:10 always read 0.
- R10: `equ` and status bit 9 are high one edge after `position` equals `cmp_val`.
- R11: While `rst` is high, every output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_en | input | 1 | Serial-clock enable that advances the period timer |
| enc_a | input | 1 | Quadrature input A (asynchronous) |
| enc_b | input | 1 | Quadrature input B (asynchronous) |
| hall_uvw | input | 3 | Hall sensor state {U,V,W} |
| demux_err | input | 1 | Bad multiplexed-sample flag from the input demux |
| cnt_clr | input | 1 | Synchronous clear of the position and the error flag |
| cmp_val | input | CNT_W | Position compare value |
| position | output | CNT_W | Position count |
| status_word | output | 16 | Status word: Hall, demux, error and compare bits |
| period_word | output | TMR_W | Serial-clock enables between the last two counts |
| equ | output | 1 | Position-compare match |

## Verification
If the direction decode is wrong, `position` runs the wrong way on the first step of a sequence, three edges after the input moves. If the illegal-transition logic is wrong, bit 8 comes up late or never, or the count moves when it should hold. The bench keeps a behavioural model and compares every output on every cycle, so a fault in the timer restart or in saturation shows at the very next valid count. A fault in the Hall capture shows in the first count after the sensor lines change.

// File: rtl/enc_status_pkg.sv
package enc_status_pkg;
  localparam int STAT_W   = 16;
  localparam int HALL_LSB = 0;
  localparam int DMX_BIT  = 3;
  localparam int ERR_BIT  = 8;
  localparam int EQU_BIT  = 9;

  typedef logic [1:0] ab_t;
endpackage

// File: rtl/quad_step_decode.sv
module quad_step_decode #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic a_in,
  input  logic b_in,
  output logic step,
  output logic up,
  output logic illegal
);
  import enc_status_pkg::*;

  logic [SYNC_STAGES-1:0] a_chain, b_chain;
  ab_t cur_ab, prev_ab, diff;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          a_chain <= '0;
          b_chain <= '0;
        end else begin
          a_chain <= a_in;
          b_chain <= b_in;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          a_chain <= '0;
          b_chain <= '0;
        end else begin
          a_chain <= {a_chain[SYNC_STAGES-2:0], a_in};
          b_chain <= {b_chain[SYNC_STAGES-2:0], b_in};
        end
      end
    end
  endgenerate

  assign cur_ab = {a_chain[SYNC_STAGES-1], b_chain[SYNC_STAGES-1]};

  always_ff @(posedge clk) begin
    if (rst) prev_ab <= '0;
    else     prev_ab <= cur_ab;
  end

  always_comb begin
    diff    = cur_ab ^ prev_ab;
    step    = (diff == 2'b01) || (diff == 2'b10);
    illegal = (diff == 2'b11);
    up      = prev_ab[0] ^ cur_ab[1];
  end
endmodule

// File: rtl/count_period_timer.sv
module count_period_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             restart,
  output logic [TMR_W-1:0] tmr_cnt,
  output logic [TMR_W-1:0] period_q
);
  localparam logic [TMR_W-1:0] TMR_MAX = {TMR_W{1'b1}};

  logic [TMR_W-1:0] with_tick;

  always_comb begin
    with_tick = tmr_cnt;
    if (tick && (tmr_cnt != TMR_MAX)) with_tick = tmr_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_cnt  <= '0;
      period_q <= '0;
    end else if (restart) begin
      period_q <= with_tick;
      tmr_cnt  <= '0;
    end else begin
      tmr_cnt  <= with_tick;
    end
  end
endmodule

// File: rtl/pos_track.sv
module pos_track #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  input  logic             up,
  input  logic             illegal,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] pos_q,
  output logic             err_q,
  output logic             equ_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      err_q <= 1'b0;
      equ_q <= 1'b0;
    end else begin
      equ_q <= (pos_q == cmp_val);
      if (clr) begin
        pos_q <= '0;
        err_q <= 1'b0;
      end else begin
        if (step) pos_q <= up ? pos_q + 1'b1 : pos_q - 1'b1;
        if (illegal) err_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/enc_status_capture.sv
module enc_status_capture #(
  parameter int CNT_W       = 16,
  parameter int TMR_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_en,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic [2:0]       hall_uvw,
  input  logic             demux_err,
  input  logic             cnt_clr,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] position,
  output logic [15:0]      status_word,
  output logic [TMR_W-1:0] period_word,
  output logic             equ
);
  import enc_status_pkg::*;

  logic             step, up, illegal, err_q, dmx_q;
  logic [2:0]       hall_q;
  logic [TMR_W-1:0] tmr_cnt;

  quad_step_decode #(.SYNC_STAGES(SYNC_STAGES)) u_dec (
    .clk(clk), .rst(rst), .a_in(enc_a), .b_in(enc_b),
    .step(step), .up(up), .illegal(illegal)
  );

  count_period_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst(rst), .tick(sclk_en), .restart(step),
    .tmr_cnt(tmr_cnt), .period_q(period_word)
  );

  pos_track #(.CNT_W(CNT_W)) u_pos (
    .clk(clk), .rst(rst), .clr(cnt_clr), .step(step), .up(up),
    .illegal(illegal), .cmp_val(cmp_val),
    .pos_q(position), .err_q(err_q), .equ_q(equ)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hall_q <= '0;
      dmx_q  <= 1'b0;
    end else begin
      dmx_q <= demux_err;
      if (step) hall_q <= hall_uvw;
    end
  end

  always_comb begin
    status_word                   = '0;
    status_word[HALL_LSB +: 3]    = hall_q;
    status_word[DMX_BIT]          = dmx_q;
    status_word[ERR_BIT]          = err_q;
    status_word[EQU_BIT]          = equ;
  end
endmodule

// File: rtl/enc_status_chk.sv
module enc_status_chk #(
  parameter int CNT_W = 16,
  parameter int TMR_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_clr,
  input logic [CNT_W-1:0] cmp_val,
  input logic [CNT_W-1:0] position,
  input logic [15:0]      status_word,
  input logic             equ,
  input logic             step,
  input logic             illegal,
  input logic [TMR_W-1:0] tmr_cnt
);
  localparam logic [TMR_W-1:0] TMR_MAX = {TMR_W{1'b1}};

  p_illegal_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (illegal && !cnt_clr) |=> $stable(position));

  p_illegal_flag_r3: assert property (@(posedge clk) disable iff (rst)
    (illegal && !cnt_clr) |=> status_word[8]);

  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> (position == '0) && !status_word[8]);

  p_restart_r5: assert property (@(posedge clk) disable iff (rst)
    step |=> (tmr_cnt == '0));

  p_saturate_r6: assert property (@(posedge clk) disable iff (rst)
    ((tmr_cnt == TMR_MAX) && !step) |=> (tmr_cnt == TMR_MAX));

  p_zero_bits_r9: assert property (@(posedge clk) disable iff (rst)
    (status_word[7:4] == 4'b0) && (status_word[15:10] == 6'b0));

  p_equ_match_r10: assert property (@(posedge clk) disable iff (rst)
    equ |-> ($past(position) == $past(cmp_val)) && status_word[9]);
endmodule

bind enc_status_capture enc_status_chk #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_chk (
  .clk(clk), .rst(rst), .cnt_clr(cnt_clr), .cmp_val(cmp_val),
  .position(position), .status_word(status_word), .equ(equ),
  .step(step), .illegal(illegal), .tmr_cnt(tmr_cnt)
);

// File: tb/tb_enc_status_capture.sv
module tb_enc_status_capture;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int TMR_W = 6;
  localparam int TMAX  = (1 << TMR_W) - 1;
  localparam int CMASK = (1 << CNT_W) - 1;

  logic clk = 0, rst = 1, sclk_en = 0, enc_a = 0, enc_b = 0;
  logic [2:0] hall_uvw = 0;
  logic demux_err = 0, cnt_clr = 0;
  logic [CNT_W-1:0] cmp_val = 16'd5;
  logic [CNT_W-1:0] position;
  logic [15:0] status_word;
  logic [TMR_W-1:0] period_word;
  logic equ;

  int checks = 0, fails = 0, cyc = 0, sdiv = 1, st = 0;
  bit done = 0;

  // behavioural model state
  int m_s1a, m_s2a, m_da, m_s1b, m_s2b, m_db;
  int m_pos, m_tmr, m_per, m_hall, m_err, m_equ, m_dmx;

  enc_status_capture #(.CNT_W(CNT_W), .TMR_W(TMR_W)) dut (
    .clk(clk), .rst(rst), .sclk_en(sclk_en), .enc_a(enc_a), .enc_b(enc_b),
    .hall_uvw(hall_uvw), .demux_err(demux_err), .cnt_clr(cnt_clr),
    .cmp_val(cmp_val), .position(position), .status_word(status_word),
    .period_word(period_word), .equ(equ)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    int adiff, bdiff, stp, ill, upd, nt;
    cyc++;
    if (rst) begin
      m_s1a = 0; m_s2a = 0; m_da = 0; m_s1b = 0; m_s2b = 0; m_db = 0;
      m_pos = 0; m_tmr = 0; m_per = 0; m_hall = 0; m_err = 0; m_equ = 0; m_dmx = 0;
    end else begin
      adiff = m_s2a ^ m_da;
      bdiff = m_s2b ^ m_db;
      stp = adiff ^ bdiff;
      ill = adiff & bdiff;
      upd = m_db ^ m_s2a;
      m_equ = (m_pos == int'(cmp_val)) ? 1 : 0;
      if (cnt_clr) begin
        m_pos = 0; m_err = 0;
      end else begin
        if (stp != 0) m_pos = (upd != 0) ? ((m_pos + 1) & CMASK) : ((m_pos - 1) & CMASK);
        if (ill != 0) m_err = 1;
      end
      nt = m_tmr + ((sclk_en && m_tmr < TMAX) ? 1 : 0);
      if (stp != 0) begin
        m_per = nt; m_tmr = 0; m_hall = hall_uvw;
      end else m_tmr = nt;
      m_dmx = demux_err;
      m_da = m_s2a; m_s2a = m_s1a; m_s1a = enc_a;
      m_db = m_s2b; m_s2b = m_s1b; m_s1b = enc_b;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R2 position", position, m_pos);
      check("R5 period", period_word, m_per);
      check("R7 hall bits", status_word[2:0], m_hall);
      check("R8 demux bit", status_word[3], m_dmx);
      check("R9 zero bits", {status_word[15:10], status_word[7:4]}, 0);
      check("R3 error bit", status_word[8], m_err);
      check("R10 equ", equ, m_equ);
      check("R10 status bit9", status_word[9], m_equ);
    end
  end

  always @(negedge clk) sclk_en <= (cyc % sdiv) == 0;

  task automatic put_state(input int s);
    case (s & 3)
      0: {enc_a, enc_b} = 2'b00;
      1: {enc_a, enc_b} = 2'b10;
      2: {enc_a, enc_b} = 2'b11;
      default: {enc_a, enc_b} = 2'b01;
    endcase
  endtask

  task automatic move(input int dir, input int gap);
    st = st + dir;
    put_state(st);
    repeat (gap) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset position", position, 0);
    check("R11 reset status", status_word, 0);
    check("R11 reset period", period_word, 0);
    check("R11 reset equ", equ, 0);
    rst = 0;
    repeat (4) @(negedge clk);

    // R1 latency: third edge
    p0 = position;
    move(1, 0);
    @(negedge clk); check("R1 no change after edge 1", position, p0);
    @(negedge clk); check("R1 no change after edge 2", position, p0);
    @(negedge clk); check("R1 change after edge 3", position, (p0 + 1) & CMASK);
    repeat (3) @(negedge clk);

    // R2/R7 forward with hall changes, sclk every 2 cycles
    sdiv = 2;
    for (int i = 0; i < 8; i++) begin
      hall_uvw = 3'(i);
      move(1, 4 + i);
    end
    repeat (4) @(negedge clk);
    check("R2 forward total", position, 9);
    // reverse, wrap below zero
    sdiv = 1;
    for (int i = 0; i < 12; i++) move(-1, 3);
    repeat (4) @(negedge clk);
    check("R2 reverse wrap", position, CMASK - 2);

    // R8 demux flag
    demux_err = 1; @(negedge clk); demux_err = 0; repeat (2) @(negedge clk);

    // R3 illegal: jump two states
    st = st + 2; put_state(st);
    repeat (5) @(negedge clk);
    check("R3 flag set", status_word[8], 1);
    check("R3 position held", position, CMASK - 2);

    // R4 clear, coinciding with a step
    move(1, 2);
    cnt_clr = 1; @(negedge clk); cnt_clr = 0;
    repeat (3) @(negedge clk);
    check("R4 cleared flag", status_word[8], 0);

    // R10 compare: walk up to cmp_val
    for (int i = 0; i < 8; i++) move(1, 4);
    repeat (4) @(negedge clk);

    // R6 saturation
    sdiv = 1;
    repeat (TMAX + 20) @(negedge clk);
    move(1, 5);
    check("R6 saturated period", period_word, TMAX);
    move(-1, 10);
    repeat (5) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule